// File: doc/BRIEF.md
# Complementary Output Dead-Time Inserter

This block takes one reference PWM level and turns it into a pair of complementary outputs: a main output that follows the reference and a complementary output that follows its inverse. On every reference edge, the output that is switching off goes inactive at once. The output that is switching on waits for a programmable dead time, so the two outputs are never active together. The dead time is set by an 8-bit code. The code is decoded into a number of dead-time ticks in one of four ranges, and each range has its own base offset and step size. One tick lasts `TICK_DIV` clock cycles.

A main output enable selects between running and idle operation. While running, each output is driven only when its own channel enable is set. While idle, an off-state selection input decides between two behaviours. In the first, both outputs and their enable signals are released to 0. In the second, each enabled output is actively held at its own programmed idle level.

Top module: `dt_pair`

## Requirements
- R1: For a code with bit 7 = 0, the dead time is code[6:0] ticks, that is code × TICK_DIV clock cycles.
- R2: For code[7:6] = 2'b10, the dead time is (64 + code[5:0]) × 2 ticks.
- R3: For code[7:5] = 3'b110, the dead time is (32 + code[4:0]) × 8 ticks.
- R4: For code[7:5] = 3'b111, the dead time is (32 + code[4:0]) × 16 ticks.
- R5: A rising reference edge is sampled at a clock edge k. The complementary internal level drops after edge k, and the main internal level rises after edge k + D, where D is the dead time in clocks loaded at edge k. The two internal levels are never both 1.
- R6: A falling reference edge mirrors R5. The main level drops after edge k, and the complementary level rises after edge k + D.
- R7: A reference edge that arrives while a dead-time count is running restarts the count from the current code. The output that was still waiting stays inactive for that pulse.
- R8: A code of 0 gives zero dead time. Both internal levels change after the same clock edge that samples the reference edge.
- R9: With main_en = 0 and idle_sel = 0, out_p, out_n, oe_p and oe_n are all 0.
- R10: With main_en = 0 and idle_sel = 1, each output whose channel enable is 1 has its enable at 1 and its level equal to its idle level. A disabled channel has level 0 and enable 0.
- R11: With main_en = 1, oe_p = en_p and oe_n = en_n. An output whose channel enable is 0 is driven 0. An enabled output carries its dead-time-processed level.
- R12: After reset, the reference is taken as low and settled: the main level is 0 and the complementary level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Reference PWM level |
| dt_code | input | 8 | Dead-time code |
| main_en | input | 1 | Main output enable (1 = running) |
| idle_sel | input | 1 | Off-state selection while idle |
| en_p | input | 1 | Main output channel enable |
| en_n | input | 1 | Complementary output channel enable |
| idle_p | input | 1 | Idle level of the main output |
| idle_n | input | 1 | Idle level of the complementary output |
| out_p | output | 1 | Main output level |
| out_n | output | 1 | Complementary output level |
| oe_p | output | 1 | Main output enable signal |
| oe_n | output | 1 | Complementary output enable signal |

## Verification
The bench builds the block with TICK_DIV = 2. Every dead time is therefore twice its tick count in clocks, which exposes any error in how ticks are scaled to clocks. At this setting even the longest code in the top range, about two thousand clocks, stays short enough to run in full. The codes chosen reach all four decode ranges. The bench also drives pulses shorter than the dead time, a zero code, and every combination of enables and idle levels.

// File: rtl/dt_pair.sv
module dt_pair #(
  parameter int TICK_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [7:0] dt_code,
  input  logic       main_en,
  input  logic       idle_sel,
  input  logic       en_p,
  input  logic       en_n,
  input  logic       idle_p,
  input  logic       idle_n,
  output logic       out_p,
  output logic       out_n,
  output logic       oe_p,
  output logic       oe_n
);
  localparam int MAX_TICKS = (32 + 31) * 16;
  localparam int MAX_CLKS  = MAX_TICKS * TICK_DIV;
  localparam int CNT_W     = $clog2(MAX_CLKS + 1);

  function automatic logic [CNT_W-1:0] code_ticks(input logic [7:0] c);
    logic [CNT_W-1:0] t;
    if (!c[7])              t = CNT_W'(c[6:0]);
    else if (!c[6])         t = CNT_W'({1'b1, c[5:0]}) << 1;
    else if (!c[5])         t = CNT_W'({1'b1, c[4:0]}) << 3;
    else                    t = CNT_W'({1'b1, c[4:0]}) << 4;
    return t;
  endfunction

  logic [CNT_W-1:0] load_clks;
  logic [CNT_W-1:0] cnt;
  logic             ref_r, p_act, n_act;
  logic             edge_seen;

  assign load_clks = code_ticks(dt_code) * CNT_W'(TICK_DIV);
  assign edge_seen = ref_in != ref_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r <= 1'b0;
      p_act <= 1'b0;
      n_act <= 1'b1;
      cnt   <= '0;
    end else if (edge_seen) begin
      ref_r <= ref_in;
      if (load_clks == '0) begin
        p_act <= ref_in;
        n_act <= !ref_in;
        cnt   <= '0;
      end else begin
        p_act <= 1'b0;
        n_act <= 1'b0;
        cnt   <= load_clks;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        p_act <= ref_r;
        n_act <= !ref_r;
      end
    end
  end

  assign oe_p  = en_p & (main_en | idle_sel);
  assign oe_n  = en_n & (main_en | idle_sel);
  assign out_p = en_p & (main_en ? p_act : (idle_sel & idle_p));
  assign out_n = en_n & (main_en ? n_act : (idle_sel & idle_n));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_act && n_act));
  a_r5_main_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_act) |-> ref_r);
  a_r6_comp_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(n_act) |-> !ref_r);
  a_r8_settled_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (p_act == ref_r && n_act == !ref_r));
  a_r7_edge_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && load_clks != '0) |=> (!p_act && !n_act));
endmodule

// File: tb/dt_pair_test.sv
module dt_pair_test;
  localparam int TD = 2;
  logic clk = 0, rst_n = 0;
  logic ref_in = 0, main_en = 1, idle_sel = 0, en_p = 1, en_n = 1, idle_p = 0, idle_n = 0;
  logic [7:0] dt_code = 8'h05;
  logic out_p, out_n, oe_p, oe_n;
  int checks = 0, fails = 0;
  string tag = "R12";
  bit cmp_on = 0;

  dt_pair #(.TICK_DIV(TD)) uut (.clk, .rst_n, .ref_in, .dt_code, .main_en, .idle_sel,
    .en_p, .en_n, .idle_p, .idle_n, .out_p, .out_n, .oe_p, .oe_n);

  always #4 clk = !clk;

  function automatic int ticks_of(input logic [7:0] c);
    if (c[7] == 1'b0) return c;
    if (c[6] == 1'b0) return (64 + c[5:0]) * 2;
    if (c[5] == 1'b0) return (32 + c[4:0]) * 8;
    return (32 + c[4:0]) * 16;
  endfunction

  int cyc, last_edge, dly;
  bit lvl;
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_edge = -1000000; lvl = 0; dly = 0;
    end else begin
      cyc++;
      if (ref_in !== lvl) begin
        lvl = ref_in; last_edge = cyc; dly = ticks_of(dt_code) * TD;
      end
    end
  end

  task automatic chk(input string t, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: {out_p,out_n,oe_p,oe_n} actual %b expected %b", t, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    bit settled, ep, en;
    logic [3:0] e;
    settled = (cyc - last_edge) >= dly;
    ep = lvl && settled;
    en = !lvl && settled;
    e[1] = en_p & (main_en | idle_sel);
    e[0] = en_n & (main_en | idle_sel);
    e[3] = en_p & (main_en ? ep : (idle_sel & idle_p));
    e[2] = en_n & (main_en ? en : (idle_sel & idle_n));
    chk(tag, {out_p, out_n, oe_p, oe_n}, e);
  end

  task automatic wait_c(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_pair(input logic [7:0] c, input int hold);
    dt_code = c;
    ref_in = 1; wait_c(hold);
    ref_in = 0; wait_c(hold);
  endtask

  initial begin
    wait_c(3);
    rst_n = 1;
    @(negedge clk);
    chk("R12", {out_p, out_n, oe_p, oe_n}, 4'b0111);
    #2;
    cmp_on = 1;
    tag = "R5"; dt_code = 8'h05; ref_in = 1; wait_c(30);
    tag = "R6"; ref_in = 0; wait_c(30);
    tag = "R1"; pulse_pair(8'h3A, 130); pulse_pair(8'h7F, 270);
    tag = "R2"; pulse_pair(8'h83, 300); pulse_pair(8'hBF, 520);
    tag = "R3"; pulse_pair(8'hC2, 600);
    tag = "R4"; pulse_pair(8'hE1, 1100); pulse_pair(8'hFF, 2050);
    tag = "R7"; dt_code = 8'h10;
    ref_in = 1; wait_c(10); ref_in = 0; wait_c(70);
    ref_in = 1; wait_c(70); ref_in = 0; wait_c(5); ref_in = 1; wait_c(70);
    ref_in = 0; wait_c(70);
    tag = "R8"; dt_code = 8'h00;
    for (int i = 0; i < 8; i++) begin ref_in = !ref_in; wait_c(1 + i % 3); end
    ref_in = 0; wait_c(4);
    tag = "R9"; dt_code = 8'h04; main_en = 0; idle_sel = 0; idle_p = 1; idle_n = 1;
    pulse_pair(8'h04, 20);
    tag = "R10"; idle_sel = 1;
    for (int i = 0; i < 16; i++) begin
      {en_p, en_n, idle_p, idle_n} = 4'(i);
      ref_in = i[0]; wait_c(3);
    end
    tag = "R11"; main_en = 1; idle_sel = 0; en_p = 0; en_n = 1;
    pulse_pair(8'h06, 25);
    en_p = 1; en_n = 0; pulse_pair(8'h06, 25);
    en_n = 1; pulse_pair(8'h06, 25);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule